// File: doc/BRIEF.md
# Motor PWM Channel Generator

This block produces the waveform for one motor-control PWM channel. A timer counter shared by all channels arrives as an input, together with the frame period. The channel compares the counter against a duty magnitude and forms a left-, right- or center-aligned pulse. It can delay that pulse by up to three timer clocks. It then routes the pulse to a plus/minus pin pair, and in one mode also to a second mirrored pair. Each pin has its own value output and its own drive-enable output. A pin whose drive-enable is low is released.

A single write port sets the alignment, the output mode, the delay, the sign and the duty. Alignment, output mode, sign and duty go into a shadow copy first. They reach the working copy at the end of the overflow cycle of the timer counter, so a frame is never changed halfway. There is one exception: if every channel is idle, or the period is zero, the working copy loads at once. The readback port always shows the shadow, which is the value written last. When the channel is disabled or the period is cleared, the drive-enables drop after the next overflow edge. This release does not wait for the channel delay.

Top module: `motor_pwm_chan`

## Requirements
- R1: With working alignment 01 (left), the pulse is high in a frame cycle whose counter value t satisfies t < duty.
- R2: With working alignment 10 (right), the pulse is high when t + duty >= period.
- R3: With working alignment 11 (center), the pulse is high when -duty <= 2t - period < duty. Alignment 00 means disabled, and the pulse stays low.
- R4: A duty of zero gives a pulse that is low for the whole frame. A duty of at least the period gives a pulse that is high for the whole frame. Both hold for every non-disabled alignment.
- R5: Output mode 00 drives only the minus pin, which carries the pulse, and releases the plus pin. Output mode 01 drives only the plus pin, which carries the pulse, and releases the minus pin.
- R6: Output mode 10 drives both pins of the first pair. With sign 0 the pulse goes on plus and minus is held at 0. With sign 1 the pulse goes on minus and plus is held at 0.
- R7: Output mode 11 behaves like mode 10 and copies the first pair's values and enables onto the second pair. In every other mode the second pair is released and held at 0.
- R8: When neither immediate-load condition (R9) holds, a new alignment, output mode, sign or duty written in a cycle that is not an overflow takes effect in the cycle after the next overflow. An overflow cycle is one where counter = period - 1, or where the period is zero. A write made in an overflow cycle takes effect in the next cycle.
- R9: If the period is zero, or the peers-idle input is high while the channel's own working alignment is 00, a write takes effect in the next cycle.
- R10: The readback outputs show the alignment and output mode from the most recent write, one cycle after that write.
- R11: The pulse reaches the pins 1 + d cycles after the counter value that produced it, where d is the delay field (0 to 3). A new delay value applies from the cycle after its write.
- R12: If the next working alignment is 00 or the period is zero, an overflow releases all pins on the following edge, regardless of the delay. An active channel is driven again as soon as its enabled setting loads.
- R13: After reset, all pins are released and at 0, the readback is 0, and the duty, sign and delay are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tc_i | input | CW | Shared timer counter value |
| period_i | input | CW | Frame period, 0 means cleared |
| peers_off_i | input | 1 | All other channels are disabled |
| wr_en_i | input | 1 | Write strobe for the setting fields |
| wr_align_i | input | 2 | Alignment: 00 off, 01 left, 10 right, 11 center |
| wr_omode_i | input | 2 | Output mode: 00 half on minus, 01 half on plus, 10 full, 11 dual full |
| wr_delay_i | input | DLW | Channel delay in timer clocks |
| wr_sign_i | input | 1 | Direction sign for the full-bridge modes |
| wr_duty_i | input | CW | Duty magnitude |
| rd_align_o | output | 2 | Last written alignment |
| rd_omode_o | output | 2 | Last written output mode |
| pin_p_o | output | 1 | Plus pin value, first pair |
| pin_m_o | output | 1 | Minus pin value, first pair |
| pin_p2_o | output | 1 | Plus pin value, second pair |
| pin_m2_o | output | 1 | Minus pin value, second pair |
| drv_p_o | output | 1 | Plus pin drive-enable, first pair |
| drv_m_o | output | 1 | Minus pin drive-enable, first pair |
| drv_p2_o | output | 1 | Plus pin drive-enable, second pair |
| drv_m2_o | output | 1 | Minus pin drive-enable, second pair |

## Verification
A working setting that loads at the wrong moment shows up within one frame. Pulse edges move before the overflow where they belong, or the readback disagrees with the pins for a whole frame. A wrong delay tap shifts every pulse edge by a fixed number of cycles, and the pin trace exposes this on the first edge. A stuck release flag leaves the enables high, or low, in the cycle right after an overflow that should have changed them. The bench builds the expected pin vector for every cycle from the counter it drives and compares it in the very next cycle.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  typedef enum logic [1:0] {
    AL_OFF    = 2'b00,
    AL_LEFT   = 2'b01,
    AL_RIGHT  = 2'b10,
    AL_CENTER = 2'b11
  } align_e;

  typedef enum logic [1:0] {
    OM_HALF_M = 2'b00,
    OM_HALF_P = 2'b01,
    OM_FULL   = 2'b10,
    OM_DUAL   = 2'b11
  } omode_e;

  typedef struct packed {
    align_e align;
    omode_e omode;
  } mode_t;
endpackage

// File: rtl/mpwm_cfg_buf.sv
module mpwm_cfg_buf
  import mpwm_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           load,
  input  mode_t          wr_mode,
  input  logic           wr_sign,
  input  logic [DW-1:0]  wr_duty,
  input  logic [DLW-1:0] wr_dly,
  output mode_t          rd_mode,
  output mode_t          wk_mode,
  output align_e         nx_align,
  output logic           wk_sign,
  output logic [DW-1:0]  wk_duty,
  output logic [DLW-1:0] dly
);
  mode_t          sh_mode;
  logic           sh_sign;
  logic [DW-1:0]  sh_duty;
  mode_t          src_mode;
  logic           src_sign;
  logic [DW-1:0]  src_duty;

  // A write in the load cycle goes straight through to the working copy
  always_comb begin
    src_mode = wr_en ? wr_mode : sh_mode;
    src_sign = wr_en ? wr_sign : sh_sign;
    src_duty = wr_en ? wr_duty : sh_duty;
    nx_align = load ? src_mode.align : wk_mode.align;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mode <= '0;
      sh_sign <= 1'b0;
      sh_duty <= '0;
      dly     <= '0;
      wk_mode <= '0;
      wk_sign <= 1'b0;
      wk_duty <= '0;
    end else begin
      if (wr_en) begin
        sh_mode <= wr_mode;
        sh_sign <= wr_sign;
        sh_duty <= wr_duty;
        dly     <= wr_dly;
      end
      if (load) begin
        wk_mode <= src_mode;
        wk_sign <= src_sign;
        wk_duty <= src_duty;
      end
    end
  end

  assign rd_mode = sh_mode;
endmodule

// File: rtl/mpwm_cmp.sv
module mpwm_cmp
  import mpwm_pkg::*;
#(
  parameter int CW   = 8,
  parameter int MAXD = 3,
  parameter int DLW  = $clog2(MAXD + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  align_e         align,
  input  logic [CW-1:0]  tc,
  input  logic [CW-1:0]  per,
  input  logic [CW-1:0]  duty,
  input  logic [DLW-1:0] dly,
  output logic           pwm_q
);
  // Pulse level for one counter value; center mode works on doubled counts
  function automatic logic frame_on(align_e a, logic [CW-1:0] t,
                                    logic [CW-1:0] p, logic [CW-1:0] d);
    logic [CW:0] t2, lo, hi;
    t2 = {t, 1'b0};
    lo = {1'b0, p} - {1'b0, d};
    hi = {1'b0, p} + {1'b0, d};
    if (a == AL_OFF || d == '0) return 1'b0;
    if (d >= p)                 return 1'b1;
    case (a)
      AL_LEFT:  return t < d;
      AL_RIGHT: return {1'b0, t} >= lo;
      default:  return (t2 >= lo) && (t2 < hi);
    endcase
  endfunction

  logic            raw_w;
  logic [MAXD-1:0] chain_q;
  logic [MAXD:0]   taps_w;

  assign raw_w  = frame_on(align, tc, per, duty);
  assign taps_w = {chain_q, raw_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      chain_q[0] <= raw_w;
      for (int i = 1; i < MAXD; i++) chain_q[i] <= chain_q[i-1];
      pwm_q <= taps_w[dly];
    end
  end
endmodule

// File: rtl/mpwm_pin_map.sv
module mpwm_pin_map
  import mpwm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwm,
  input  omode_e omode,
  input  logic   sign,
  input  logic   act_nx,
  input  logic   ovf,
  output logic   pin_p,
  output logic   pin_m,
  output logic   pin_p2,
  output logic   pin_m2,
  output logic   drv_p,
  output logic   drv_m,
  output logic   drv_p2,
  output logic   drv_m2
);
  logic rel_q;

  // Release is taken at overflow and bypasses the delay chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rel_q <= 1'b1;
    else if (act_nx) rel_q <= 1'b0;
    else if (ovf)    rel_q <= 1'b1;
  end

  always_comb begin
    {pin_p, pin_m, pin_p2, pin_m2} = '0;
    {drv_p, drv_m, drv_p2, drv_m2} = '0;
    if (!rel_q) begin
      case (omode)
        OM_HALF_M: begin drv_m = 1'b1; pin_m = pwm; end
        OM_HALF_P: begin drv_p = 1'b1; pin_p = pwm; end
        default: begin
          drv_p = 1'b1;
          drv_m = 1'b1;
          pin_p = pwm & ~sign;
          pin_m = pwm & sign;
          if (omode == OM_DUAL) begin
            drv_p2 = 1'b1;
            drv_m2 = 1'b1;
            pin_p2 = pwm & ~sign;
            pin_m2 = pwm & sign;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/motor_pwm_chan.sv
module motor_pwm_chan
  import mpwm_pkg::*;
#(
  parameter  int CW   = 8,
  parameter  int MAXD = 3,
  localparam int DLW  = $clog2(MAXD + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  tc_i,
  input  logic [CW-1:0]  period_i,
  input  logic           peers_off_i,
  input  logic           wr_en_i,
  input  logic [1:0]     wr_align_i,
  input  logic [1:0]     wr_omode_i,
  input  logic [DLW-1:0] wr_delay_i,
  input  logic           wr_sign_i,
  input  logic [CW-1:0]  wr_duty_i,
  output logic [1:0]     rd_align_o,
  output logic [1:0]     rd_omode_o,
  output logic           pin_p_o,
  output logic           pin_m_o,
  output logic           pin_p2_o,
  output logic           pin_m2_o,
  output logic           drv_p_o,
  output logic           drv_m_o,
  output logic           drv_p2_o,
  output logic           drv_m2_o
);
  mode_t          wr_mode_w, rd_mode_w, wk_mode;
  align_e         nx_align_w;
  logic           wk_sign_w;
  logic [CW-1:0]  wk_duty_w;
  logic [DLW-1:0] dly_w;
  logic           pwm_w;

  // Named events for the checker
  logic           ovf_w, imm_w, load_w, act_nx_w;
  logic [1:0]     wk_align_w, wk_omode_w;

  assign wr_mode_w  = '{align: align_e'(wr_align_i), omode: omode_e'(wr_omode_i)};
  assign ovf_w      = (period_i == '0) || (tc_i == period_i - 1'b1);
  assign imm_w      = (period_i == '0) || (peers_off_i && wk_mode.align == AL_OFF);
  assign load_w     = ovf_w || imm_w;
  assign act_nx_w   = (nx_align_w != AL_OFF) && (period_i != '0);
  assign wk_align_w = wk_mode.align;
  assign wk_omode_w = wk_mode.omode;

  mpwm_cfg_buf #(.DW(CW), .DLW(DLW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .load(load_w),
    .wr_mode(wr_mode_w), .wr_sign(wr_sign_i), .wr_duty(wr_duty_i), .wr_dly(wr_delay_i),
    .rd_mode(rd_mode_w), .wk_mode(wk_mode), .nx_align(nx_align_w),
    .wk_sign(wk_sign_w), .wk_duty(wk_duty_w), .dly(dly_w)
  );

  mpwm_cmp #(.CW(CW), .MAXD(MAXD), .DLW(DLW)) cmp_i (
    .clk(clk), .rst_n(rst_n), .align(wk_mode.align), .tc(tc_i), .per(period_i),
    .duty(wk_duty_w), .dly(dly_w), .pwm_q(pwm_w)
  );

  mpwm_pin_map map_i (
    .clk(clk), .rst_n(rst_n), .pwm(pwm_w), .omode(wk_mode.omode), .sign(wk_sign_w),
    .act_nx(act_nx_w), .ovf(ovf_w),
    .pin_p(pin_p_o), .pin_m(pin_m_o), .pin_p2(pin_p2_o), .pin_m2(pin_m2_o),
    .drv_p(drv_p_o), .drv_m(drv_m_o), .drv_p2(drv_p2_o), .drv_m2(drv_m2_o)
  );

  assign rd_align_o = rd_mode_w.align;
  assign rd_omode_o = rd_mode_w.omode;
endmodule

// File: rtl/motor_pwm_chan_chk.sv
module motor_pwm_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovf_w,
  input logic       load_w,
  input logic       act_nx_w,
  input logic [1:0] wk_align_w,
  input logic [1:0] wk_omode_w,
  input logic       wr_en_i,
  input logic [1:0] wr_align_i,
  input logic [1:0] rd_align_o,
  input logic       pin_p_o,
  input logic       pin_m_o,
  input logic       drv_p_o,
  input logic       drv_m_o,
  input logic       drv_p2_o,
  input logic       drv_m2_o
);
  // R8: working settings move only in a load cycle
  a_r8_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !load_w |=> ($stable(wk_align_w) && $stable(wk_omode_w)));

  // R10: readback follows the last write
  a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (rd_align_o == $past(wr_align_i)));

  // R12: an overflow with no active next setting releases every pin
  a_r12_release_at_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_w && !act_nx_w) |=> !(drv_p_o || drv_m_o || drv_p2_o || drv_m2_o));

  // R6: the two pins of a pair never carry the pulse together
  a_r6_no_both_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_p_o && pin_m_o));

  // R7: the second pair is driven only in dual mode
  a_r7_pair2_dual_only: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_p2_o || drv_m2_o) |-> (wk_omode_w == 2'b11));
endmodule

bind motor_pwm_chan motor_pwm_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ovf_w(ovf_w), .load_w(load_w), .act_nx_w(act_nx_w),
  .wk_align_w(wk_align_w), .wk_omode_w(wk_omode_w), .wr_en_i(wr_en_i),
  .wr_align_i(wr_align_i), .rd_align_o(rd_align_o), .pin_p_o(pin_p_o),
  .pin_m_o(pin_m_o), .drv_p_o(drv_p_o), .drv_m_o(drv_m_o),
  .drv_p2_o(drv_p2_o), .drv_m2_o(drv_m2_o)
);

// File: tb/motor_pwm_chan_tb_top.sv
module motor_pwm_chan_tb_top;
  localparam int  CW   = 8;
  localparam time TCLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(TCLK/2) clk = ~clk;

  logic [CW-1:0] tc_i = '0, period_i = '0, wr_duty_i = '0;
  logic peers_off_i = 1'b0, wr_en_i = 1'b0, wr_sign_i = 1'b0;
  logic [1:0] wr_align_i = '0, wr_omode_i = '0, wr_delay_i = '0;
  logic [1:0] rd_align_o, rd_omode_o;
  logic pin_p_o, pin_m_o, pin_p2_o, pin_m2_o, drv_p_o, drv_m_o, drv_p2_o, drv_m2_o;

  motor_pwm_chan #(.CW(CW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R13";

  // Bench model state
  int P = 0, tcv = 0, k = 8, c_du = 0, s_du = 0, dlyq = 0;
  logic [1:0] c_al = '0, c_om = '0, s_al = '0, s_om = '0;
  logic c_sg = 1'b0, s_sg = 1'b0, rel = 1'b1, peers = 1'b0;
  logic hist [8];
  logic [7:0] exp_v = '0;
  logic [3:0] exp_rd = '0;

  function automatic logic f_on(logic [1:0] al, int t, int p, int d);
    if (al == 2'b00 || d == 0) return 1'b0;
    if (d >= p) return 1'b1;
    case (al)
      2'b01:   return t < d;
      2'b10:   return t + d >= p;
      default: return (2*t - p >= -d) && (2*t - p < d);
    endcase
  endfunction

  // bits: 0 pin_p, 1 pin_m, 2 pin_p2, 3 pin_m2, 4 drv_p, 5 drv_m, 6 drv_p2, 7 drv_m2
  function automatic logic [7:0] f_pins(logic r, logic [1:0] om, logic sg, logic w);
    logic [7:0] v = '0;
    if (r) return v;
    case (om)
      2'b00: begin v[5] = 1'b1; v[1] = w; end
      2'b01: begin v[4] = 1'b1; v[0] = w; end
      default: begin
        v[4] = 1'b1; v[5] = 1'b1;
        if (sg) v[1] = w; else v[0] = w;
        if (om == 2'b11) begin v[6] = 1'b1; v[7] = 1'b1; v[2] = v[0]; v[3] = v[1]; end
      end
    endcase
    return v;
  endfunction

  task automatic chk(string t, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", t, k, got, exp);
    end
  endtask

  task automatic cyc(bit wr, logic [1:0] al, logic [1:0] om, logic [1:0] dl, logic sg, int du);
    logic ovf, imm, w;
    @(negedge clk);
    chk(tag, {drv_m2_o, drv_p2_o, drv_m_o, drv_p_o, pin_m2_o, pin_p2_o, pin_m_o, pin_p_o}, exp_v);
    chk("R10", {4'b0, rd_align_o, rd_omode_o}, {4'b0, exp_rd});
    tc_i = tcv[CW-1:0]; period_i = P[CW-1:0]; peers_off_i = peers;
    wr_en_i = wr; wr_align_i = al; wr_omode_i = om; wr_delay_i = dl;
    wr_sign_i = sg; wr_duty_i = du[CW-1:0];
    hist[k % 8] = f_on(c_al, tcv, P, c_du);
    w = hist[(k - dlyq) % 8];
    ovf = (P == 0) || (tcv == P - 1);
    imm = (P == 0) || (peers && c_al == 2'b00);
    if (wr) begin s_al = al; s_om = om; s_sg = sg; s_du = du; end
    if (ovf || imm) begin c_al = s_al; c_om = s_om; c_sg = s_sg; c_du = s_du; end
    if (c_al != 2'b00 && P != 0) rel = 1'b0;
    else if (ovf) rel = 1'b1;
    if (wr) dlyq = dl;
    exp_v  = f_pins(rel, c_om, c_sg, w);
    exp_rd = {s_al, s_om};
    tcv = (P == 0) ? 0 : ((tcv >= P - 1) ? 0 : tcv + 1);
    k++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 0);
  endtask

  task automatic to_ovf();
    while (!(P == 0 || tcv == P - 1)) cyc(1'b0, 2'b00, 2'b00, 2'b00, 1'b0, 0);
  endtask

  initial begin
    int plist[4] = '{1, 2, 5, 8};
    for (int i = 0; i < 8; i++) hist[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R13"; idle(3);

    // R1 R2 R3 R4 sweep, full bridge with alternating sign (R6)
    foreach (plist[pi]) begin
      P = plist[pi]; tcv = 0;
      for (int al = 1; al < 4; al++) begin
        for (int du = 0; du <= P + 1; du++) begin
          tag = (du == 0 || du >= P) ? "R4" : (al == 1 ? "R1" : (al == 2 ? "R2" : "R3"));
          to_ovf();
          cyc(1'b1, al[1:0], 2'b10, 2'b00, du[0], du);
          idle(2*P + 2);
        end
      end
    end

    // R5 R6 R7 output modes
    P = 6; tcv = 0;
    for (int om = 0; om < 4; om++) begin
      for (int sg = 0; sg < 2; sg++) begin
        tag = (om < 2) ? "R5" : (om == 2 ? "R6" : "R7");
        to_ovf();
        cyc(1'b1, 2'b01, om[1:0], 2'b00, sg[0], 2);
        idle(14);
      end
    end

    // R11 delay sweep
    P = 5; tcv = 0; tag = "R11";
    for (int dl = 0; dl < 4; dl++) begin
      to_ovf();
      cyc(1'b1, 2'b01, 2'b10, dl[1:0], 1'b0, 2);
      idle(12);
    end

    // R8 mid-frame write waits for overflow
    P = 8; tcv = 0; tag = "R8";
    to_ovf();
    cyc(1'b1, 2'b01, 2'b10, 2'b00, 1'b0, 2);
    idle(10);
    cyc(1'b1, 2'b10, 2'b00, 2'b00, 1'b1, 6);
    idle(20);

    // R12 release ignores delay, then cleared period
    P = 6; tcv = 0; tag = "R12";
    to_ovf();
    cyc(1'b1, 2'b01, 2'b00, 2'b11, 1'b0, 6);
    idle(9);
    cyc(1'b1, 2'b00, 2'b00, 2'b11, 1'b0, 6);
    idle(14);
    to_ovf();
    cyc(1'b1, 2'b01, 2'b01, 2'b11, 1'b0, 6);
    idle(8);
    P = 0; tcv = 0;
    idle(4);

    // R9 immediate load while all peers idle and own channel off
    P = 8; tcv = 0; tag = "R9";
    idle(3);
    cyc(1'b1, 2'b00, 2'b00, 2'b00, 1'b0, 0);
    idle(12);
    peers = 1'b1;
    idle(3);
    cyc(1'b1, 2'b01, 2'b10, 2'b00, 1'b0, 4);
    idle(12);
    peers = 1'b0;
    idle(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule